// File: doc/BRIEF.md
# Coalescing Interrupt Source Bank

A bank of interrupt sources, each holding a two-bit state: a pending bit (P, bit 1) and a queued bit (Q, bit 0). A source that fires while idle sends one notification, carrying its index, toward a downstream router. Later events are folded into the Q bit until software signals end-of-interrupt (EOI). This keeps at most one notification per source in flight. A source in the masked state (P=0, Q=1) swallows all events.

Events reach a source in three ways: a one-cycle pulse on its edge input, a rising level on its level input (for sources marked level-sensitive), or a write to its trigger page on the memory-mapped port. Software also reads and changes the state through that port. Each source owns a page of 2^PAGE_SHIFT bytes starting at index × 2^PAGE_SHIFT. When PAGE_SHIFT is 13 or 17, the page is split in two: the lower half triggers and the upper half manages. Every management read returns the state from before the access and changes it in the same step. Notifications wait in a small queue until the router accepts them through a ready/valid handshake.

Top module: `esb_source_bank`

## Requirements
- R1: After reset, every source reads state 00, no notification is offered and no read response is valid.
- R2: An event on a source in state 00 moves it to 10 and produces exactly one notification whose source field is that source's index.
- R3: An event on a source in state 10 or 11 leaves it in 11 and produces no notification.
- R4: An event on a source in state 01 (masked) leaves the state at 01 and produces no notification.
- R5: A read at management offset 0x800 returns the state in bits [1:0] and the level-asserted flag in bit 2 (other bits zero), one cycle after the request, without changing the state.
- R6: Reads at management offsets 0xC00, 0xD00, 0xE00 and 0xF00 return the previous state and force the state to 00, 01, 10 and 11 respectively, without producing a notification.
- R7: A read at management offset 0x000 is an EOI: it returns the previous state and clears the state to 00. If Q was 1, the source instead ends in 10 and a new notification is produced.
- R8: With STORE_EOI enabled (default), a write at management offset 0x400 performs the same EOI as R7.
- R9: With PAGE_SHIFT 13 (default), source n's trigger page starts at n × 0x2000 and its management page at n × 0x2000 + 0x1000. A write anywhere in the trigger page is an event, and a read there returns 0 and changes nothing.
- R10: A level-sensitive source (LSI_MASK bit set, sources 6 and 7 by default) shows its input level in status bit 2. A rising level is an event. An EOI while the level is still high leaves the source in 10 and produces a new notification.
- R11: Notifications are held, with valid and source stable, while the router is not ready. Notifications raised in the same cycle leave in ascending source order, and the queue never exceeds its depth.
- R12: Accesses to a source index at or above N_SRC, or to an undefined management offset, change no state, produce no notification and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | N_SRC | One-cycle event pulses, one per source |
| lvl_i | input | N_SRC | Level lines, used by level-sensitive sources |
| req_valid_i | input | 1 | Bus access strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address of the access |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_data_o | output | 64 | Read data: previous state and asserted flag |
| ntf_valid_o | output | 1 | A notification is offered |
| ntf_ready_i | input | 1 | Router accepts the offered notification |
| ntf_src_o | output | SRC_W | Index of the notifying source |

## Verification
The state machine is driven from each of its four states with edge pulses, trigger-page writes and rising levels. This separates a first event, which notifies, from a coalesced event and from a masked one, both of which must stay silent. EOI is applied both by load and by store, with Q set and with Q clear, and on a level source with its line high and low. This separates a re-notifying EOI from a clearing one. Three sources firing in the same cycle against a stalled router show the queue ordering and the hold behaviour. Reads outside the bank, on the trigger page and at undefined offsets show that stray accesses have no effect.

// File: rtl/esb_pkg.sv
package esb_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI,
    OP_GET,
    OP_SET
  } esb_op_e;

  typedef struct packed {
    esb_op_e    kind;
    logic [1:0] pq;
  } esb_cmd_t;

  localparam logic [1:0] PQ_IDLE   = 2'b00;
  localparam logic [1:0] PQ_OFF    = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_QUEUED = 2'b11;

  localparam logic [11:0] OFS_EOI_LOAD  = 12'h000;
  localparam logic [11:0] OFS_EOI_STORE = 12'h400;
  localparam logic [11:0] OFS_GET       = 12'h800;
  localparam logic [11:0] OFS_SET_BASE  = 12'hC00;
  localparam logic [11:0] OFS_SET_FIELD = 12'h300;

endpackage

// File: rtl/esb_addr_dec.sv
module esb_addr_dec
  import esb_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int PAGE_SHIFT = 13,
  parameter bit STORE_EOI  = 1'b1,
  parameter int SRC_W      = 3,
  parameter int ADDR_W     = 17
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [SRC_W-1:0]  src,
  output esb_cmd_t          cmd
);

  localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);
  localparam int OFF_W    = TWO_PAGE ? PAGE_SHIFT - 1 : PAGE_SHIFT;
  localparam int IDX_W    = ADDR_W - PAGE_SHIFT;

  logic [IDX_W-1:0] page_idx;
  logic [OFF_W-1:0] off;
  logic             in_mgmt;

  assign page_idx = req_addr[ADDR_W-1:PAGE_SHIFT];
  assign off      = req_addr[OFF_W-1:0];
  assign in_mgmt  = TWO_PAGE ? req_addr[PAGE_SHIFT-1] : 1'b1;
  assign hit      = req_valid && (page_idx < IDX_W'(N_SRC));
  assign src      = page_idx[SRC_W-1:0];

  always_comb begin
    cmd = '{kind: OP_NONE, pq: PQ_IDLE};
    if (hit) begin
      if (req_write) begin
        if (TWO_PAGE && !in_mgmt) begin
          cmd.kind = OP_TRIG;
        end else if (STORE_EOI && off == OFF_W'(OFS_EOI_STORE)) begin
          cmd.kind = OP_EOI;
        end else if (!TWO_PAGE) begin
          cmd.kind = OP_TRIG;
        end
      end else if (in_mgmt) begin
        if (off == OFF_W'(OFS_EOI_LOAD)) begin
          cmd.kind = OP_EOI;
        end else if (off == OFF_W'(OFS_GET)) begin
          cmd.kind = OP_GET;
        end else if ((off & ~OFF_W'(OFS_SET_FIELD)) == OFF_W'(OFS_SET_BASE)) begin
          cmd.kind = OP_SET;
          cmd.pq   = off[9:8];
        end
      end
    end
  end

endmodule

// File: rtl/esb_src_cell.sv
module esb_src_cell
  import esb_pkg::*;
#(
  parameter bit IS_LSI = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  esb_cmd_t   cmd,
  input  logic       hw_edge,
  input  logic       lvl,
  output logic [1:0] pq,
  output logic       asserted,
  output logic       notify
);

  logic [1:0] pq_q, pq_d, pq_mid;
  logic       asrt_q, asrt_d;
  logic       trig, eoi_ntf, trig_ntf, pq_en;

  assign trig = hw_edge || (cmd.kind == OP_TRIG) || (IS_LSI && lvl && !asrt_q);

  // Software operation first, then any event on the resulting state.
  always_comb begin
    pq_mid  = pq_q;
    eoi_ntf = 1'b0;
    case (cmd.kind)
      OP_EOI: begin
        if (pq_q[0] || (IS_LSI && asrt_q)) begin
          pq_mid  = PQ_PEND;
          eoi_ntf = 1'b1;
        end else begin
          pq_mid = PQ_IDLE;
        end
      end
      OP_SET:  pq_mid = cmd.pq;
      default: pq_mid = pq_q;
    endcase
  end

  always_comb begin
    pq_d     = pq_mid;
    trig_ntf = 1'b0;
    if (trig) begin
      case (pq_mid)
        PQ_IDLE: begin
          pq_d     = PQ_PEND;
          trig_ntf = 1'b1;
        end
        PQ_PEND, PQ_QUEUED: pq_d = PQ_QUEUED;
        default:            pq_d = PQ_OFF;
      endcase
    end
  end

  assign pq_en  = trig || (cmd.kind == OP_EOI) || (cmd.kind == OP_SET);
  assign asrt_d = IS_LSI ? lvl : 1'b0;
  assign notify = eoi_ntf || trig_ntf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq_q <= PQ_IDLE;
    end else if (pq_en) begin
      pq_q <= pq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asrt_q <= 1'b0;
    end else begin
      asrt_q <= asrt_d;
    end
  end

  assign pq       = pq_q;
  assign asserted = asrt_q;

  assert_notify_sets_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
    notify |=> pq_q[1]);

  assert_coalesce_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_q[1] && cmd.kind == OP_NONE) |-> !notify);

  assert_masked_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_q == PQ_OFF && cmd.kind == OP_NONE) |=> pq_q == PQ_OFF);

endmodule

// File: rtl/esb_ntf_fifo.sv
module esb_ntf_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] data
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign data    = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = do_push && (wr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (slot_en) begin
        mem_q[g] <= push_data;
      end
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/esb_source_bank.sv
module esb_source_bank
  import esb_pkg::*;
#(
  parameter int               N_SRC      = 8,
  parameter int               PAGE_SHIFT = 13,
  parameter bit               STORE_EOI  = 1'b1,
  parameter logic [N_SRC-1:0] LSI_MASK   = N_SRC'(8'hC0),
  parameter int               QDEPTH     = 4,
  localparam int              SRC_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int              ADDR_W     = SRC_W + PAGE_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_pulse_i,
  input  logic [N_SRC-1:0]  lvl_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_data_o,
  output logic              ntf_valid_o,
  input  logic              ntf_ready_i,
  output logic [SRC_W-1:0]  ntf_src_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Address decode.
  logic             hit;
  logic [SRC_W-1:0] sel;
  esb_cmd_t         cmd;

  esb_addr_dec #(
    .N_SRC(N_SRC), .PAGE_SHIFT(PAGE_SHIFT), .STORE_EOI(STORE_EOI),
    .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .req_valid(req_valid_i), .req_write(req_write_i), .req_addr(req_addr_i),
    .hit(hit), .src(sel), .cmd(cmd)
  );

  // Source cells.
  logic [1:0]       pq_arr [N_SRC];
  logic [N_SRC-1:0] asrt_vec, ntf_vec;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    esb_cmd_t cell_cmd;
    assign cell_cmd = (hit && sel == SRC_W'(g)) ? cmd : '{kind: OP_NONE, pq: PQ_IDLE};
    esb_src_cell #(.IS_LSI(LSI_MASK[g])) u_cell (
      .clk(clk), .rst_n(rst_ni), .cmd(cell_cmd),
      .hw_edge(evt_pulse_i[g]), .lvl(lvl_i[g]),
      .pq(pq_arr[g]), .asserted(asrt_vec[g]), .notify(ntf_vec[g])
    );
  end

  // Read response: state before the access.
  logic        rsp_valid_q, rsp_valid_d;
  logic [63:0] rsp_data_q, rsp_data_d;
  logic        status_rd;

  assign status_rd   = hit && !req_write_i &&
                       (cmd.kind == OP_EOI || cmd.kind == OP_GET || cmd.kind == OP_SET);
  assign rsp_valid_d = req_valid_i && !req_write_i;

  always_comb begin
    rsp_data_d = '0;
    if (status_rd) rsp_data_d[2:0] = {asrt_vec[sel], pq_arr[sel]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  // Outstanding notification flags, drained lowest index first.
  logic [N_SRC-1:0] req_q, req_d, take_mask;
  logic [SRC_W-1:0] pick;
  logic             any_req, q_full, q_push;

  always_comb begin
    pick    = '0;
    any_req = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_q[i]) begin
        pick    = SRC_W'(i);
        any_req = 1'b1;
      end
    end
  end

  assign q_push    = any_req && !q_full;
  assign take_mask = q_push ? (N_SRC'(1) << pick) : '0;
  assign req_d     = (req_q & ~take_mask) | ntf_vec;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  esb_ntf_fifo #(.DEPTH(QDEPTH), .W(SRC_W)) u_fifo (
    .clk(clk), .rst_n(rst_ni),
    .push(q_push), .push_data(pick), .full(q_full),
    .pop(ntf_ready_i), .valid(ntf_valid_o), .data(ntf_src_o)
  );

  assert_read_resp_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  assert_hold_offer_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (ntf_valid_o && !ntf_ready_i) |=> (ntf_valid_o && $stable(ntf_src_o)));

  assert_stray_silent_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid_i && !hit) |=> rsp_data_o == 64'd0);

endmodule

// File: tb/test_esb_source_bank.sv
module test_esb_source_bank;

  localparam int N     = 8;
  localparam int SHIFT = 13;
  localparam int SW    = 3;
  localparam int AW    = SW + SHIFT + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  evt, lvl;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic          ntf_valid, ntf_ready;
  logic [SW-1:0] ntf_src;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  esb_source_bank i_esb_source_bank (
    .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt), .lvl_i(lvl),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .ntf_valid_o(ntf_valid), .ntf_ready_i(ntf_ready), .ntf_src_o(ntf_src)
  );

  function automatic logic [AW-1:0] trig_a(int s, int ofs);
    return AW'(s * 32'h2000 + ofs);
  endfunction

  function automatic logic [AW-1:0] mgmt_a(int s, int ofs);
    return AW'(s * 32'h2000 + 32'h1000 + ofs);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic bus_write(logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, longint exp, string tag);
    logic [63:0] d;
    bus_read(a, d);
    check(d == 64'(exp), tag, d, exp);
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic pop_ntf(int exp, string tag);
    bit seen = 1'b0;
    for (int k = 0; k < 12 && !seen; k++) begin
      @(negedge clk);
      if (ntf_valid) seen = 1'b1;
    end
    check(seen, {tag, " valid"}, seen, 1);
    if (seen) begin
      check(ntf_src == SW'(exp), {tag, " src"}, ntf_src, exp);
      ntf_ready = 1'b1;
      @(negedge clk);
      ntf_ready = 1'b0;
    end
  endtask

  task automatic no_ntf(string tag);
    repeat (4) @(negedge clk);
    check(!ntf_valid, {tag, " no notification"}, ntf_valid, 0);
  endtask

  task automatic t_reset;
    check(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);
    check(!ntf_valid, "R1 ntf_valid", ntf_valid, 0);
    for (int s = 0; s < N; s++) rd_chk(mgmt_a(s, 'h800), 0, "R1 idle state");
  endtask

  task automatic t_edge;
    pulse(8'h02);
    pop_ntf(1, "R2 first event");
    no_ntf("R2 single");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = mgmt_a(1, 'h800);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid, "R5 rsp_valid next cycle", rsp_valid, 1);
    check(rsp_data == 64'h2, "R5 get pending", rsp_data, 2);
    rd_chk(mgmt_a(1, 'h800), 2, "R5 get unchanged");
  endtask

  task automatic t_coalesce;
    pulse(8'h02);
    pulse(8'h02);
    no_ntf("R3 coalesced");
    rd_chk(mgmt_a(1, 'h800), 3, "R3 queued state");
  endtask

  task automatic t_eoi_load;
    rd_chk(mgmt_a(1, 'h000), 3, "R7 eoi returns prior");
    pop_ntf(1, "R7 re-notify on Q");
    rd_chk(mgmt_a(1, 'h800), 2, "R7 back to pending");
    rd_chk(mgmt_a(1, 'h000), 2, "R7 eoi prior pending");
    no_ntf("R7 plain eoi");
    rd_chk(mgmt_a(1, 'h800), 0, "R7 cleared");
  endtask

  task automatic t_masked;
    rd_chk(mgmt_a(2, 'hD00), 0, "R6 set01 prior");
    pulse(8'h04);
    no_ntf("R4 masked");
    rd_chk(mgmt_a(2, 'h800), 1, "R4 stays off");
    rd_chk(mgmt_a(2, 'hC00), 1, "R6 set00 prior");
  endtask

  task automatic t_set;
    rd_chk(mgmt_a(3, 'hE00), 0, "R6 set10 prior");
    no_ntf("R6 set silent");
    rd_chk(mgmt_a(3, 'hF00), 2, "R6 set11 prior");
    rd_chk(mgmt_a(3, 'h800), 3, "R6 set11 took");
    rd_chk(mgmt_a(3, 'hC00), 3, "R6 set00 prior");
    rd_chk(mgmt_a(3, 'h800), 0, "R6 set00 took");
    no_ntf("R6 set silent 2");
  endtask

  task automatic t_store_eoi;
    pulse(8'h10);
    pop_ntf(4, "R8 first");
    pulse(8'h10);
    bus_write(mgmt_a(4, 'h400));
    pop_ntf(4, "R8 store eoi re-notify");
    rd_chk(mgmt_a(4, 'h800), 2, "R8 pending after store eoi");
    bus_write(mgmt_a(4, 'h400));
    rd_chk(mgmt_a(4, 'h800), 0, "R8 cleared by store eoi");
    no_ntf("R8 plain store eoi");
  endtask

  task automatic t_trig_page;
    bus_write(trig_a(5, 'h10));
    pop_ntf(5, "R9 trigger page write");
    rd_chk(trig_a(5, 'h800), 0, "R9 trigger page read zero");
    rd_chk(mgmt_a(5, 'h800), 2, "R9 state via mgmt page");
    rd_chk(mgmt_a(5, 'hC00), 2, "R9 cleanup");
  endtask

  task automatic t_lsi;
    @(negedge clk); lvl[6] = 1'b1;
    pop_ntf(6, "R10 level rise");
    rd_chk(mgmt_a(6, 'h800), 6, "R10 asserted+pending");
    rd_chk(mgmt_a(6, 'h000), 6, "R10 eoi prior");
    pop_ntf(6, "R10 eoi while high");
    rd_chk(mgmt_a(6, 'h800), 6, "R10 still pending");
    @(negedge clk); lvl[6] = 1'b0;
    rd_chk(mgmt_a(6, 'h800), 2, "R10 deasserted");
    rd_chk(mgmt_a(6, 'h000), 2, "R10 eoi low prior");
    no_ntf("R10 eoi while low");
    rd_chk(mgmt_a(6, 'h800), 0, "R10 idle");
  endtask

  task automatic t_queue;
    bit stable = 1'b1;
    pulse(8'h89);
    repeat (6) @(negedge clk);
    check(ntf_valid, "R11 offer while stalled", ntf_valid, 1);
    check(ntf_src == 3'd0, "R11 head is lowest", ntf_src, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!ntf_valid || ntf_src != 3'd0) stable = 1'b0;
    end
    check(stable, "R11 held stable", stable, 1);
    pop_ntf(0, "R11 order 1");
    pop_ntf(3, "R11 order 2");
    pop_ntf(7, "R11 order 3");
    no_ntf("R11 drained");
    rd_chk(mgmt_a(0, 'hC00), 2, "R11 cleanup 0");
    rd_chk(mgmt_a(3, 'hC00), 2, "R11 cleanup 3");
    rd_chk(mgmt_a(7, 'hC00), 2, "R11 cleanup 7");
  endtask

  task automatic t_range;
    rd_chk(AW'(8 * 32'h2000 + 32'h1800), 0, "R12 out of range get");
    bus_write(AW'(8 * 32'h2000 + 32'h10));
    no_ntf("R12 out of range trigger");
    rd_chk(mgmt_a(0, 'hE00), 0, "R12 setup");
    rd_chk(mgmt_a(0, 'h900), 0, "R12 undefined offset");
    rd_chk(mgmt_a(0, 'h800), 2, "R12 state unchanged");
    rd_chk(mgmt_a(0, 'hC00), 2, "R12 cleanup");
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; lvl = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; ntf_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_edge();
    t_coalesce();
    t_eoi_load();
    t_masked();
    t_set();
    t_store_eoi();
    t_trig_page();
    t_lsi();
    t_queue();
    t_range();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule